// File: doc/BRIEF.md
# Multi-source reset controller

This block merges four reset requests into three registered reset outputs for a chip. An external reset request pin and a watchdog timeout pulse arrive asynchronously. A software reset bit is set through a one-bit register write port. A fourth input, the memory-reset enable, decides whether a reset also reaches the SDRAM controller. Software and debug flows can therefore reset the core and peripherals while the memory controller keeps refreshing and the stored data survives.

The external inputs and the watchdog pulse each pass through a synchroniser. The block then sorts each new reset event into one of four kinds: master, normal, watchdog or software. It latches the memory-reset enable once, when the event starts. Each output is held for a programmable number of cycles after the last active source and is released synchronously. A sticky cause register records which kinds of reset have occurred. Only a master reset clears it.

Top module: `rst_hub`

## Requirements
- R1: The external reset request, the memory-reset enable and the watchdog pulse each pass through SYNC_STAGES (default 2) flops. A rising external request therefore raises `core_rst_o` on the third clock edge after it is applied, and not on the second.
- R2: A master reset is the external request together with a synchronised enable of 1 when the event starts. It asserts `core_rst_o`, `pin_rst_o` and `mem_rst_o`, and sets `cause_o` to exactly 4'b0001.
- R3: A normal reset is the external request with the enable at 0 when the event starts. It asserts `core_rst_o` and `pin_rst_o`, leaves `mem_rst_o` low throughout, and sets `cause_o` bit 1.
- R4: Writing 1 with `sw_wr_en` sets the software bit. `sw_rst_bit` reads 1 for exactly one cycle and then clears itself. The resulting pulse asserts `core_rst_o` and `pin_rst_o`, sets `cause_o` bit 3, and asserts `mem_rst_o` only when the enable is 1.
- R5: A watchdog pulse with no external request asserts `core_rst_o` and `pin_rst_o` and sets `cause_o` bit 2. It asserts `mem_rst_o` only when the enable is 1.
- R6: Each output stays asserted for HOLD_CYCLES+1 cycles (default 17) after the last cycle in which a synchronised source was active, then drops on a clock edge. A lone software pulse gives exactly 17 asserted cycles, and an output never rises for a single cycle only.
- R7: The enable is sampled only when a reset event starts, which is the first cycle with any source active after an idle cycle. Changing it while the event is in progress does not change `mem_rst_o`.
- R8: `cause_o` bits accumulate across non-master resets: bit 0 is master, bit 1 normal, bit 2 watchdog and bit 3 software. Only a master reset, or `rst`, clears the other bits. The register changes only on a cycle in which `core_rst_o` is asserted.
- R9: When several kinds are present at the start of an event, only the highest is recorded, in the order master, normal, watchdog, software. A simultaneous watchdog and software pulse records the watchdog only.
- R10: `pin_rst_o` equals `core_rst_o` on every cycle.
- R11: While `rst` (synchronous, active high) is asserted, all three reset outputs are 1, `cause_o` is 4'b0001 and `sw_rst_bit` is 0. After `rst` is released, the outputs follow the R6 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset of the block itself |
| ext_rst_req | input | 1 | Asynchronous external reset request, active high |
| mem_rst_en | input | 1 | Asynchronous enable: 1 lets resets reach the memory controller |
| wdog_tmo | input | 1 | Watchdog timeout pulse, asynchronous, active high |
| sw_wr_en | input | 1 | Write strobe for the software reset bit |
| sw_wr_data | input | 1 | Write data: 1 requests a software reset |
| sw_rst_bit | output | 1 | Readback of the software reset bit |
| core_rst_o | output | 1 | Core and peripheral reset |
| mem_rst_o | output | 1 | SDRAM controller reset |
| pin_rst_o | output | 1 | External reset output pin |
| cause_o | output | 4 | Sticky reset cause: bit 0 master, 1 normal, 2 watchdog, 3 software |

## Verification
The external request is applied with the enable high and with it low, which separates a master reset from a normal one on `mem_rst_o` and on the cause bits. Watchdog and software pulses are each applied with both enable levels, which shows that the enable alone decides whether memory is reset. Toggling the enable halfway through a held request shows that the enable is sampled only when the event starts. Aligning a watchdog pulse and a software write on the same cycle checks the recording priority, and a lone software pulse measures the exact hold length.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
  localparam int CAUSE_W   = 4;
  localparam int CB_MASTER = 0;
  localparam int CB_NORMAL = 1;
  localparam int CB_WDOG   = 2;
  localparam int CB_SOFT   = 3;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_MASTER,
    RK_NORMAL,
    RK_WDOG,
    RK_SOFT
  } rst_kind_e;
endpackage

// File: rtl/rst_hub_sync.sv
module rst_hub_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rst_hub_stretch.sv
module rst_hub_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic q
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || trig) begin
      cnt <= CW'(HOLD);
      q   <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
      q   <= 1'b1;
    end else begin
      q   <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_hub_classify.sv
module rst_hub_classify
  import rst_hub_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_s,
  input  logic               en_s,
  input  logic               wd_s,
  input  logic               sw_act,
  output logic               core_trig,
  output logic               mem_trig,
  output logic [CAUSE_W-1:0] cause
);
  logic      any_src, any_q, take, mem_q, mem_now;
  rst_kind_e kind;

  assign any_src = ext_s | wd_s | sw_act;
  assign take    = any_src & ~any_q;
  assign mem_now = take ? en_s : mem_q;

  always_comb begin
    if (ext_s && en_s)  kind = RK_MASTER;
    else if (ext_s)     kind = RK_NORMAL;
    else if (wd_s)      kind = RK_WDOG;
    else if (sw_act)    kind = RK_SOFT;
    else                kind = RK_NONE;
  end

  assign core_trig = any_src;
  assign mem_trig  = any_src & mem_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      any_q <= 1'b0;
      mem_q <= 1'b1;
      cause <= CAUSE_W'(1) << CB_MASTER;
    end else begin
      any_q <= any_src;
      if (take) begin
        mem_q <= en_s;
        case (kind)
          RK_MASTER: cause <= CAUSE_W'(1) << CB_MASTER;
          RK_NORMAL: cause <= cause | (CAUSE_W'(1) << CB_NORMAL);
          RK_WDOG:   cause <= cause | (CAUSE_W'(1) << CB_WDOG);
          RK_SOFT:   cause <= cause | (CAUSE_W'(1) << CB_SOFT);
          default:   cause <= cause;
        endcase
      end
    end
  end
endmodule

// File: rtl/rst_hub.sv
module rst_hub
  import rst_hub_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_rst_req,
  input  logic               mem_rst_en,
  input  logic               wdog_tmo,
  input  logic               sw_wr_en,
  input  logic               sw_wr_data,
  output logic               sw_rst_bit,
  output logic               core_rst_o,
  output logic               mem_rst_o,
  output logic               pin_rst_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int NCH = 3;

  logic [2:0]     sync_q;
  logic           sw_q;
  logic           core_trig, mem_trig;
  logic [NCH-1:0] ch_trig, ch_out;

  rst_hub_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({wdog_tmo, mem_rst_en, ext_rst_req}),
    .q   (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst)       sw_q <= 1'b0;
    else if (sw_q) sw_q <= 1'b0;
    else           sw_q <= sw_wr_en & sw_wr_data;
  end

  rst_hub_classify u_cls (
    .clk       (clk),
    .rst       (rst),
    .ext_s     (sync_q[0]),
    .en_s      (sync_q[1]),
    .wd_s      (sync_q[2]),
    .sw_act    (sw_q),
    .core_trig (core_trig),
    .mem_trig  (mem_trig),
    .cause     (cause_o)
  );

  assign ch_trig = {core_trig, mem_trig, core_trig};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rst_hub_stretch #(.HOLD(HOLD_CYCLES)) u_str (
      .clk  (clk),
      .rst  (rst),
      .trig (ch_trig[c]),
      .q    (ch_out[c])
    );
  end

  assign core_rst_o = ch_out[0];
  assign mem_rst_o  = ch_out[1];
  assign pin_rst_o  = ch_out[2];
  assign sw_rst_bit = sw_q;
endmodule

// File: rtl/rst_hub_chk.sv
module rst_hub_chk (
  input logic       clk,
  input logic       rst,
  input logic       sw_rst_bit,
  input logic       core_rst_o,
  input logic       mem_rst_o,
  input logic       pin_rst_o,
  input logic [3:0] cause_o
);
  // R10
  pin_match_chk: assert property (@(posedge clk) disable iff (rst)
    pin_rst_o == core_rst_o);

  // R2
  mem_within_core_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rst_o |-> core_rst_o);

  // R4
  sw_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sw_rst_bit |=> !sw_rst_bit);

  // R6
  no_glitch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst_o) |=> core_rst_o);

  // R8
  cause_change_chk: assert property (@(posedge clk) disable iff (rst)
    (cause_o != $past(cause_o)) |-> core_rst_o);

  // R8
  cause_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cause_o != 4'b0000);
endmodule

bind rst_hub rst_hub_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sw_rst_bit (sw_rst_bit),
  .core_rst_o (core_rst_o),
  .mem_rst_o  (mem_rst_o),
  .pin_rst_o  (pin_rst_o),
  .cause_o    (cause_o)
);

// File: tb/rst_hub_bench.sv
module rst_hub_bench;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_rst_req = 1'b0, mem_rst_en = 1'b0, wdog_tmo = 1'b0;
  logic sw_wr_en = 1'b0, sw_wr_data = 1'b0;
  logic sw_rst_bit, core_rst_o, mem_rst_o, pin_rst_o;
  logic [3:0] cause_o;

  always #2.5 clk = ~clk;

  rst_hub u_rst_hub (
    .clk(clk), .rst(rst), .ext_rst_req(ext_rst_req), .mem_rst_en(mem_rst_en),
    .wdog_tmo(wdog_tmo), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .sw_rst_bit(sw_rst_bit), .core_rst_o(core_rst_o), .mem_rst_o(mem_rst_o),
    .pin_rst_o(pin_rst_o), .cause_o(cause_o)
  );

  int checks = 0, fails = 0;
  string tag = "R11";
  bit mem_seen = 0;
  int core_hi = 0;

  // behavioural reference model
  int e1 = 0, e2 = 0, n1 = 0, n2 = 0, w1 = 0, w2 = 0;
  int m_sw = 0, m_prev = 0, m_mem = 1, m_cause = 1;
  int cnt_c = HOLD, cnt_m = HOLD;
  int o_c = 1, o_m = 1;

  always @(posedge clk) begin
    int act, start, memsel, tc, tm, nsw;
    if (rst) begin
      e1 = 0; e2 = 0; n1 = 0; n2 = 0; w1 = 0; w2 = 0;
      m_sw = 0; m_prev = 0; m_mem = 1; m_cause = 1;
      cnt_c = HOLD; cnt_m = HOLD; o_c = 1; o_m = 1;
    end else begin
      act    = (e2 || w2 || m_sw) ? 1 : 0;
      start  = (act && !m_prev) ? 1 : 0;
      memsel = start ? n2 : m_mem;
      tc = act;
      tm = act && memsel;
      if (start) begin
        m_mem = n2;
        if (e2 && n2) m_cause = 1;
        else if (e2)  m_cause = m_cause | 2;
        else if (w2)  m_cause = m_cause | 4;
        else          m_cause = m_cause | 8;
      end
      m_prev = act;
      if (tc) begin cnt_c = HOLD; o_c = 1; end
      else if (cnt_c > 0) begin cnt_c = cnt_c - 1; o_c = 1; end
      else o_c = 0;
      if (tm) begin cnt_m = HOLD; o_m = 1; end
      else if (cnt_m > 0) begin cnt_m = cnt_m - 1; o_m = 1; end
      else o_m = 0;
      nsw = m_sw ? 0 : ((sw_wr_en && sw_wr_data) ? 1 : 0);
      m_sw = nsw;
      e2 = e1; n2 = n1; w2 = w1;
      e1 = ext_rst_req; n1 = mem_rst_en; w1 = wdog_tmo;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      if (mem_rst_o) mem_seen = 1;
      if (core_rst_o) core_hi++;
      check(core_rst_o == o_c[0], tag, "core_rst_o vs model", core_rst_o, o_c);
      check(mem_rst_o == o_m[0], tag, "mem_rst_o vs model", mem_rst_o, o_m);
      check(pin_rst_o == core_rst_o, "R10", "pin_rst_o vs core", pin_rst_o, core_rst_o);
      check(cause_o == m_cause[3:0], tag, "cause_o vs model", cause_o, m_cause);
      check(sw_rst_bit == m_sw[0], tag, "sw_rst_bit vs model", sw_rst_bit, m_sw);
    end
  endtask

  task automatic clear_flags();
    mem_seen = 0;
    core_hi = 0;
  endtask

  task automatic ext_pulse(input int len);
    ext_rst_req = 1'b1;
    run(len);
    ext_rst_req = 1'b0;
    run(HOLD + 12);
  endtask

  task automatic sw_write();
    sw_wr_en = 1'b1; sw_wr_data = 1'b1;
    run(1);
    check(sw_rst_bit == 1'b1, "R4", "sw bit after write", sw_rst_bit, 1);
    sw_wr_en = 1'b0; sw_wr_data = 1'b0;
    run(1);
    check(sw_rst_bit == 1'b0, "R4", "sw bit self-clear", sw_rst_bit, 0);
    run(HOLD + 10);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R11 reset state
    tag = "R11";
    run(3);
    check(core_rst_o && mem_rst_o && pin_rst_o, "R11", "outputs in rst",
          {core_rst_o, mem_rst_o, pin_rst_o}, 7);
    check(cause_o == 4'b0001, "R11", "cause in rst", cause_o, 1);
    check(sw_rst_bit == 1'b0, "R11", "sw bit in rst", sw_rst_bit, 0);
    rst = 1'b0;
    run(HOLD + 6);
    check(!core_rst_o && !mem_rst_o, "R11", "released after hold",
          {core_rst_o, mem_rst_o}, 0);

    // R1 latency, R3 normal reset
    tag = "R3";
    clear_flags();
    ext_rst_req = 1'b1;
    run(2);
    check(core_rst_o == 1'b0, "R1", "core before sync latency", core_rst_o, 0);
    run(1);
    check(core_rst_o == 1'b1, "R1", "core after 3 edges", core_rst_o, 1);
    run(3);
    ext_rst_req = 1'b0;
    run(HOLD + 12);
    check(!mem_seen, "R3", "mem during normal", mem_seen, 0);
    check(cause_o == 4'b0011, "R8", "cause accumulates normal", cause_o, 3);

    // R2 master reset
    tag = "R2";
    mem_rst_en = 1'b1;
    run(4);
    clear_flags();
    ext_pulse(4);
    check(mem_seen, "R2", "mem during master", mem_seen, 1);
    check(cause_o == 4'b0001, "R2", "master clears cause", cause_o, 1);

    // R5 watchdog, enable low then high
    tag = "R5";
    mem_rst_en = 1'b0;
    run(4);
    clear_flags();
    wdog_tmo = 1'b1; run(1); wdog_tmo = 1'b0;
    run(HOLD + 12);
    check(!mem_seen, "R5", "mem during wdog en=0", mem_seen, 0);
    check(core_hi > 0, "R5", "core during wdog", core_hi, 1);
    check(cause_o == 4'b0101, "R5", "cause wdog bit", cause_o, 5);
    mem_rst_en = 1'b1;
    run(4);
    clear_flags();
    wdog_tmo = 1'b1; run(1); wdog_tmo = 1'b0;
    run(HOLD + 12);
    check(mem_seen, "R5", "mem during wdog en=1", mem_seen, 1);

    // R4 software, enable low then high; R6 exact hold
    tag = "R4";
    mem_rst_en = 1'b0;
    run(4);
    clear_flags();
    sw_write();
    check(!mem_seen, "R4", "mem during sw en=0", mem_seen, 0);
    check(core_hi == HOLD + 1, "R6", "hold length of sw pulse", core_hi, HOLD + 1);
    check(cause_o == 4'b1101, "R8", "cause sw bit added", cause_o, 13);
    mem_rst_en = 1'b1;
    run(4);
    clear_flags();
    sw_write();
    check(mem_seen, "R4", "mem during sw en=1", mem_seen, 1);

    // R9 priority: watchdog and software together
    tag = "R9";
    ext_pulse(3);
    check(cause_o == 4'b0001, "R9", "master before priority", cause_o, 1);
    mem_rst_en = 1'b0;
    run(4);
    wdog_tmo = 1'b1;
    run(1);
    wdog_tmo = 1'b0; sw_wr_en = 1'b1; sw_wr_data = 1'b1;
    run(1);
    sw_wr_en = 1'b0; sw_wr_data = 1'b0;
    run(HOLD + 12);
    check(cause_o == 4'b0101, "R9", "wdog over sw", cause_o, 5);

    // R7 enable sampled at event start
    tag = "R7";
    mem_rst_en = 1'b1;
    run(4);
    ext_rst_req = 1'b1;
    run(6);
    mem_rst_en = 1'b0;
    run(10);
    check(mem_rst_o == 1'b1, "R7", "mem kept after enable drop", mem_rst_o, 1);
    ext_rst_req = 1'b0;
    run(HOLD + 12);
    clear_flags();
    ext_rst_req = 1'b1;
    run(6);
    mem_rst_en = 1'b1;
    run(10);
    ext_rst_req = 1'b0;
    run(HOLD + 12);
    check(!mem_seen, "R7", "mem not started by late enable", mem_seen, 0);
    check(cause_o == 4'b0011, "R7", "late enable gives normal", cause_o, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule